// File: doc/BRIEF.md
# Multi-CPU Private Register Window Decoder

This block sits in front of the private register window that up to four processor cores share. Every request carries a byte offset and the index of the core that issued it. The decoder keeps the low 12 offset bits and uses them to pick one of three targets:

- a small snoop-control register group that the block holds itself;
- the interrupt-interface port of one core;
- one of the two timers that belong to each core.

Two of the ranges are aliases of the issuing core, and the other ranges name a core explicitly. An access that resolves to a core which is not present is dropped without any error. Undefined offsets raise a one-cycle error flag. Every request gets a registered response one cycle later.

The block also routes each timer's interrupt line to its owning core. A rising edge on a timer line becomes a one-cycle pulse on a per-core 32-bit interrupt vector, at a fixed interrupt ID for that timer.

Top module: `privwin_decode`

## Requirements
- R1: Only the low 12 bits of `req_addr` take part in decoding. Addresses that differ only above bit 11 behave the same.
- R2: Offset 0x000 holds the snoop enable. Only bit 0 of a write is stored. A read returns that bit in bit 0 and zeros above it. The reset value is 0.
- R3: A read of offset 0x004 returns ((2^NCPU - 1) << 4) | (NCPU - 1).
- R4: Reads of 0x008 and 0x00C return 0 with no error. A write to 0x00C returns no error and leaves the enable bit unchanged.
- R5: Offsets 0x100 to 0x1FF drive `ic_valid` in the request cycle, with `ic_cpu` = `req_cpu` and `ic_offset` = offset bits 7:0. A read response returns `ic_rdata`.
- R6: Offsets 0x200 to 0x5FF address interrupt port (offset - 0x200) >> 8, with `ic_offset` = offset bits 7:0.
- R7: Offsets 0x600 to 0x6FF address the issuing core's timers. Offsets 0x700 to 0xAFF address core (offset - 0x700) >> 8. A read response returns `tm_rdata`.
- R8: For a timer access, `tm_index` = core * 2 + offset bit 5 and `tm_offset` = offset bits 3:0.
- R9: An interrupt or timer access whose resolved core index is NCPU or above drives no strobe. It reads 0 and sets no error.
- R10: The error flag is set, with read data 0 and no strobe, for these accesses: SCU offsets below 0x100 other than 0x000/0x004/0x008/0x00C on reads; SCU offsets other than 0x000/0x00C on writes; any offset 0xB00 and above.
- R11: Each request cycle is followed one cycle later by exactly one cycle of `rsp_valid`, with its `rsp_rdata` and `rsp_err`. Writes return data 0.
- R12: A rising edge on `tmr_irq[2c+k]` gives a one-cycle pulse on `ppi_pulse` bit c*32 + 29 + k in the next cycle. A line held high gives only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the requesting core |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Undefined offset |
| ic_valid | output | 1 | Interrupt-interface strobe |
| ic_write | output | 1 | Interrupt-interface write |
| ic_cpu | output | 2 | Target core of the interrupt interface |
| ic_offset | output | 8 | Interrupt-interface register offset |
| ic_wdata | output | 32 | Interrupt-interface write data |
| ic_rdata | input | 32 | Interrupt-interface read data, same cycle |
| tm_valid | output | 1 | Timer strobe |
| tm_write | output | 1 | Timer write |
| tm_index | output | 3 | Timer number, core*2+unit |
| tm_offset | output | 4 | Timer register offset |
| tm_wdata | output | 32 | Timer write data |
| tm_rdata | input | 32 | Timer read data, same cycle |
| tmr_irq | input | 2*NCPU | Timer interrupt levels |
| ppi_pulse | output | 32*NCPU | Per-core interrupt ID set pulses |

## Verification
Some properties are checked by assertions on every cycle:
- every request gets exactly one response in the next cycle;
- an error response carries zero data;
- at most one target strobe is active at a time;
- a timer strobe never addresses a timer that does not exist;
- the enable bit changes only on a write to it;
- an interrupt pulse never lasts longer than one cycle.

The remaining behaviour can only be shown by the bench's scenarios:
- the exact alias and per-core address arithmetic;
- the configuration word;
- dropping of accesses to absent cores;
- unit selection by bit 5;
- the mapping of interrupts to IDs.

The bench compares all of these against a separate model, over directed corner offsets and random traffic, with three cores present.

// File: rtl/privwin_pkg.sv
package privwin_pkg;
   localparam int WIN_BITS = 12;
   localparam int CPU_W    = 2;
   localparam int MAX_CPU  = 4;

   typedef enum logic [2:0] {
      RG_SCU_CTRL,
      RG_SCU_CFG,
      RG_SCU_ZERO,
      RG_IC,
      RG_TMR,
      RG_BAD
   } region_e;

   typedef struct packed {
      region_e           region;
      logic [CPU_W-1:0]  cpu;
      logic              unit;
      logic [7:0]        low;
   } dec_t;
endpackage

// File: rtl/pw_addr_decode.sv
module pw_addr_decode
   import privwin_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic [WIN_BITS-1:0] off,
   input  logic                is_write,
   input  logic [CPU_W-1:0]    req_cpu,
   output dec_t                dec,
   output logic                present
);
   logic [3:0] page;
   logic [3:0] ic_sel;
   logic [3:0] tm_sel;

   assign page   = off[11:8];
   assign ic_sel = page - 4'd2;
   assign tm_sel = page - 4'd7;

   always_comb begin
      dec.region = RG_BAD;
      dec.cpu    = req_cpu;
      dec.unit   = off[5];
      dec.low    = off[7:0];
      if (off < 12'h100) begin
         unique case (off[7:0])
            8'h00:   dec.region = RG_SCU_CTRL;
            8'h04:   dec.region = is_write ? RG_BAD : RG_SCU_CFG;
            8'h08:   dec.region = is_write ? RG_BAD : RG_SCU_ZERO;
            8'h0C:   dec.region = RG_SCU_ZERO;
            default: dec.region = RG_BAD;
         endcase
      end else if (off < 12'h200) begin
         dec.region = RG_IC;
      end else if (off < 12'h600) begin
         dec.region = RG_IC;
         dec.cpu    = ic_sel[CPU_W-1:0];
      end else if (off < 12'h700) begin
         dec.region = RG_TMR;
      end else if (off < 12'hB00) begin
         dec.region = RG_TMR;
         dec.cpu    = tm_sel[CPU_W-1:0];
      end
   end

   assign present = (int'(dec.cpu) < NCPU);
endmodule

// File: rtl/pw_scu_regs.sv
module pw_scu_regs
   import privwin_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_bit,
   output logic        enable_q,
   output logic [31:0] cfg_word
);
   localparam logic [31:0] CPU_MASK = (32'd1 << NCPU) - 32'd1;
   localparam logic [31:0] CFG_VAL  = (CPU_MASK << 4) | 32'(NCPU - 1);

   assign cfg_word = CFG_VAL;

   always_ff @(posedge clk) begin
      if (!rst_n)     enable_q <= 1'b0;
      else if (wr_en) enable_q <= wr_bit;
   end

   // R2: the enable bit moves only when it is written
   a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(enable_q));
endmodule

// File: rtl/pw_irq_steer.sv
module pw_irq_steer
   import privwin_pkg::*;
#(
   parameter int NCPU    = 4,
   parameter int ID_BASE = 29
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*NCPU-1:0]    tmr_irq,
   output logic [32*NCPU-1:0]   ppi_pulse
);
   localparam int LANES = 2 * NCPU;

   logic [LANES-1:0] prev_q;
   logic [LANES-1:0] fire_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         fire_q <= '0;
      end else begin
         prev_q <= tmr_irq;
         fire_q <= tmr_irq & ~prev_q;
      end
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign ppi_pulse[c*32 +: 32] = 32'(fire_q[c*2 +: 2]) << ID_BASE;
      for (genvar k = 0; k < 2; k++) begin : g_unit
         // R12: each edge gives a single-cycle pulse
         a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            ppi_pulse[c*32+ID_BASE+k] |=> !ppi_pulse[c*32+ID_BASE+k]);
      end
   end
endmodule

// File: rtl/privwin_decode.sv
module privwin_decode
   import privwin_pkg::*;
#(
   parameter int NCPU    = 4,
   parameter int ADDR_W  = 16,
   parameter int ID_BASE = 29
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [31:0]          req_wdata,
   input  logic [1:0]           req_cpu,
   output logic                 rsp_valid,
   output logic [31:0]          rsp_rdata,
   output logic                 rsp_err,
   output logic                 ic_valid,
   output logic                 ic_write,
   output logic [1:0]           ic_cpu,
   output logic [7:0]           ic_offset,
   output logic [31:0]          ic_wdata,
   input  logic [31:0]          ic_rdata,
   output logic                 tm_valid,
   output logic                 tm_write,
   output logic [2:0]           tm_index,
   output logic [3:0]           tm_offset,
   output logic [31:0]          tm_wdata,
   input  logic [31:0]          tm_rdata,
   input  logic [2*NCPU-1:0]    tmr_irq,
   output logic [32*NCPU-1:0]   ppi_pulse
);
   localparam int NTMR = 2 * NCPU;

   initial begin
      if (NCPU < 1 || NCPU > MAX_CPU) $error("NCPU out of range 1..4");
      if (ADDR_W < WIN_BITS)          $error("ADDR_W below window size");
      if (ID_BASE < 0 || ID_BASE > 30) $error("ID_BASE must leave room for two IDs");
   end

   dec_t        dec;
   logic        present;
   logic        enable_q;
   logic [31:0] cfg_word;
   logic        scu_wr;
   logic [31:0] rdata_d;
   logic        err_d;

   pw_addr_decode #(.NCPU(NCPU)) u_dec (
      .off      (req_addr[WIN_BITS-1:0]),
      .is_write (req_write),
      .req_cpu  (req_cpu),
      .dec      (dec),
      .present  (present)
   );

   assign scu_wr = req_valid && req_write && (dec.region == RG_SCU_CTRL);

   pw_scu_regs #(.NCPU(NCPU)) u_scu (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (scu_wr),
      .wr_bit   (req_wdata[0]),
      .enable_q (enable_q),
      .cfg_word (cfg_word)
   );

   pw_irq_steer #(.NCPU(NCPU), .ID_BASE(ID_BASE)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr_irq   (tmr_irq),
      .ppi_pulse (ppi_pulse)
   );

   assign ic_valid  = req_valid && (dec.region == RG_IC) && present;
   assign ic_write  = req_write;
   assign ic_cpu    = dec.cpu;
   assign ic_offset = dec.low;
   assign ic_wdata  = req_wdata;

   assign tm_valid  = req_valid && (dec.region == RG_TMR) && present;
   assign tm_write  = req_write;
   assign tm_index  = {dec.cpu, dec.unit};
   assign tm_offset = dec.low[3:0];
   assign tm_wdata  = req_wdata;

   always_comb begin
      rdata_d = '0;
      if (!req_write) begin
         unique case (dec.region)
            RG_SCU_CTRL: rdata_d = {31'b0, enable_q};
            RG_SCU_CFG:  rdata_d = cfg_word;
            RG_IC:       rdata_d = present ? ic_rdata : '0;
            RG_TMR:      rdata_d = present ? tm_rdata : '0;
            default:     rdata_d = '0;
         endcase
      end
   end

   assign err_d = req_valid && (dec.region == RG_BAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= req_valid ? rdata_d : '0;
         rsp_err   <= err_d;
      end
   end

   // R11: one response per request, in the next cycle
   a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R10: an error carries zero data
   a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));
   // R5: targets are strobed exclusively
   a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ic_valid, tm_valid, scu_wr}));
   // R8: timer strobes address only instantiated timers
   a_r8_tidx_range: assert property (@(posedge clk) disable iff (!rst_n)
      tm_valid |-> (int'(tm_index) < NTMR));
endmodule

// File: tb/tb_privwin_decode.sv
`timescale 1ns/1ps
module tb_privwin_decode;
   localparam int NCPU = 3;
   localparam int AW   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0]     req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic [1:0]        req_cpu = '0;
   logic              rsp_valid, rsp_err;
   logic [31:0]       rsp_rdata;
   logic              ic_valid, ic_write, tm_valid, tm_write;
   logic [1:0]        ic_cpu;
   logic [7:0]        ic_offset;
   logic [31:0]       ic_wdata, ic_rdata, tm_wdata, tm_rdata;
   logic [2:0]        tm_index;
   logic [3:0]        tm_offset;
   logic [2*NCPU-1:0] tmr_irq = '0;
   logic [32*NCPU-1:0] ppi_pulse;

   // register stubs answering in the same cycle
   assign ic_rdata = 32'hC000_0000 | (32'(ic_cpu) << 8) | 32'(ic_offset);
   assign tm_rdata = 32'hD000_0000 | (32'(tm_index) << 4) | 32'(tm_offset);

   privwin_decode #(.NCPU(NCPU), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .ic_valid(ic_valid), .ic_write(ic_write), .ic_cpu(ic_cpu),
      .ic_offset(ic_offset), .ic_wdata(ic_wdata), .ic_rdata(ic_rdata),
      .tm_valid(tm_valid), .tm_write(tm_write), .tm_index(tm_index),
      .tm_offset(tm_offset), .tm_wdata(tm_wdata), .tm_rdata(tm_rdata),
      .tmr_irq(tmr_irq), .ppi_pulse(ppi_pulse));

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic en_model = 1'b0;
   localparam logic [31:0] CFG_EXP = 32'h72; // (7<<4)|2 for three cores

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // kind: 0 ctrl, 1 cfg, 2 zero, 3 ic, 4 timer, 5 error, 6 dropped
   function automatic int model(input logic wr, input logic [11:0] off,
                                input logic [1:0] rc, output logic [1:0] c);
      int k;
      c = rc;
      if (off < 12'h100) begin
         if (off == 12'h000) k = 0;
         else if (off == 12'h004 && !wr) k = 1;
         else if (off == 12'h008 && !wr) k = 2;
         else if (off == 12'h00C) k = 2;
         else k = 5;
      end else if (off < 12'h200) k = 3;
      else if (off < 12'h600) begin k = 3; c = 2'((off - 12'h200) >> 8); end
      else if (off < 12'h700) k = 4;
      else if (off < 12'hB00) begin k = 4; c = 2'((off - 12'h700) >> 8); end
      else k = 5;
      if ((k == 3 || k == 4) && int'(c) >= NCPU) k = 6;
      return k;
   endfunction

   task automatic access(input logic wr, input logic [AW-1:0] a,
                         input logic [31:0] wd, input logic [1:0] rc);
      logic [1:0] c;
      int k;
      logic [11:0] off;
      logic [31:0] exp_rd;
      string tg;
      off = a[11:0];
      k = model(wr, off, rc, c);
      case (k)
         0: tg = "R2"; 1: tg = "R3"; 2: tg = "R4";
         3: tg = (off < 12'h200) ? "R5" : "R6";
         4: tg = "R7"; 5: tg = "R10"; default: tg = "R9";
      endcase
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_cpu = rc;
      #1;
      chk({tg, " ic strobe"}, 32'(ic_valid), 32'(k == 3));
      chk({tg, " tm strobe"}, 32'(tm_valid), 32'(k == 4));
      if (k == 3) begin
         chk({tg, " ic cpu"}, 32'(ic_cpu), 32'(c));
         chk({tg, " ic offset"}, 32'(ic_offset), 32'(off[7:0]));
         chk({tg, " ic write"}, 32'(ic_write), 32'(wr));
      end
      if (k == 4) begin
         chk("R8 tm index", 32'(tm_index), 32'({c, off[5]}));
         chk("R8 tm offset", 32'(tm_offset), 32'(off[3:0]));
      end
      exp_rd = 32'd0;
      if (!wr) begin
         case (k)
            0: exp_rd = {31'b0, en_model};
            1: exp_rd = CFG_EXP;
            3: exp_rd = 32'hC000_0000 | (32'(c) << 8) | 32'(off[7:0]);
            4: exp_rd = 32'hD000_0000 | (32'({c, off[5]}) << 4) | 32'(off[3:0]);
            default: exp_rd = 32'd0;
         endcase
      end
      if (wr && k == 0) en_model = wd[0];
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 rsp valid", 32'(rsp_valid), 32'd1);
      chk({tg, " rsp err"}, 32'(rsp_err), 32'(k == 5));
      chk({tg, " rsp data"}, rsp_rdata, exp_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", 32'(rsp_valid), 32'd0);
      chk("R12 no pulse after reset", 32'(|ppi_pulse), 32'd0);
      // directed corners
      access(1'b0, 16'h0000, 0, 0);               // R2 reset value 0
      access(1'b1, 16'h0000, 32'hFFFF_FFFE, 1);   // R2 bit 0 only
      access(1'b0, 16'h0000, 0, 0);
      access(1'b1, 16'h0000, 32'h0000_0003, 2);
      access(1'b0, 16'h0000, 0, 2);
      access(1'b1, 16'h000C, 32'h0, 0);           // R4 no effect
      access(1'b0, 16'h0000, 0, 0);
      access(1'b0, 16'h0004, 0, 0);               // R3
      access(1'b0, 16'hF004, 0, 1);               // R1 upper bits ignored
      access(1'b0, 16'hA000, 0, 1);               // R1 alias of 0x000
      access(1'b0, 16'h0008, 0, 0);
      access(1'b0, 16'h000C, 0, 0);
      access(1'b1, 16'h0004, 32'h1, 0);           // R10 write to read-only
      access(1'b0, 16'h0010, 0, 0);               // R10
      access(1'b0, 16'h0B00, 0, 0);               // R10
      access(1'b0, 16'h0FFF, 0, 0);               // R10
      access(1'b0, 16'h01FC, 0, 2);               // R5
      access(1'b0, 16'h0200, 0, 3);               // R6 core 0
      access(1'b0, 16'h04F8, 0, 0);               // R6 core 2
      access(1'b1, 16'h0504, 32'h5, 0);           // R9 core 3 absent
      access(1'b0, 16'h0510, 0, 0);               // R9
      access(1'b0, 16'h0104, 0, 3);               // R9 alias with absent core
      access(1'b0, 16'h0620, 0, 1);               // R7/R8 own second unit
      access(1'b0, 16'h070C, 0, 0);               // R8 core 0 first unit
      access(1'b0, 16'h0924, 0, 0);               // R8 core 2 unit 1
      access(1'b0, 16'h0A00, 0, 0);               // R9 timer core 3 absent
      // random traffic
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         a = AW'($urandom);
         if ($urandom % 4 == 0) a[11:0] = 12'($urandom % 20);
         access(1'($urandom), a, $urandom, 2'($urandom));
      end
      // R12 interrupt steering
      for (int l = 0; l < 2*NCPU; l++) begin
         logic [32*NCPU-1:0] exp_v;
         exp_v = '0;
         exp_v[(l/2)*32 + 29 + (l%2)] = 1'b1;
         @(negedge clk);
         tmr_irq = '0; tmr_irq[l] = 1'b1;
         @(negedge clk);
         chk("R12 pulse id", 32'(ppi_pulse == exp_v), 32'd1);
         @(negedge clk);
         chk("R12 held line single pulse", 32'(|ppi_pulse), 32'd0);
         tmr_irq = '0;
         @(negedge clk);
      end
      @(negedge clk);
      tmr_irq = 6'b100001;
      @(negedge clk);
      chk("R12 two lanes core0 id29", 32'(ppi_pulse[29]), 32'd1);
      chk("R12 two lanes core2 id30", 32'(ppi_pulse[2*32+30]), 32'd1);
      chk("R12 other bits quiet", 32'($countones(ppi_pulse)), 32'd2);
      tmr_irq = '0;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule